// File: doc/BRIEF.md
# Reloadable 16-bit Timer/Counter with Capture

This block is a 16-bit up-counter paired with a 16-bit reload/capture register. It is meant to sit beside a small microcontroller core. Control bits pick one of four modes: capture, up-counting auto-reload, up/down auto-reload, and baud-rate generation. Two enable ticks drive the count. One is a machine-cycle tick at one twelfth of the oscillator, and the other is a state tick at one half of it. The counter can also follow falling edges on an external count pin. A second external pin, the trigger, can capture the count, force a reload, or set the count direction.

Both pins pass through a synchronizer, and edges are found by comparing samples taken on successive machine-cycle ticks. A falling edge therefore needs at least two machine cycles, which limits pin counting to one twenty-fourth of the oscillator rate. The outputs are:
- an overflow flag, which software clears;
- an external-event flag;
- a one-cycle pulse on each baud-mode rollover, which feeds a serial port elsewhere;
- the live counter value and the reload/capture register value.

A shared write port lets software preset the counter and the reload register.

Top module: `tmr16_reload`

## Requirements
- R1: After reset, `cnt_val` and `rld_val` are 0x0000, and `ovf_flag`, `ext_flag` and `baud_pulse` are 0.
- R2: While `run_en` is 0, the counter holds its value whatever the ticks and the count pin do.
- R3: Timer source (`cnt_sel`=0, not baud mode): with `run_en`=1, the counter advances by exactly one for each clock cycle in which `mc_tick` is 1. `st_tick` has no effect outside baud mode.
- R4: Counter source (`cnt_sel`=1): with `run_en`=1, the counter advances by one for each falling edge of `cnt_pin`. An edge is seen when a machine-cycle sample reads 0 and the previous sample read 1. Rising edges and a steady pin do not count.
- R5: Up-count reload mode (`cap_sel`=0, `updown_en`=0, not baud mode): a step taken from 0xFFFF loads the counter from `rld_val` and sets `ovf_flag`. The flag stays 1 until `clr_ovf` is pulsed.
- R6: Capture mode (`cap_sel`=1, not baud mode): a step from 0xFFFF wraps the counter to 0x0000 and sets `ovf_flag`, leaving `rld_val` unchanged. With `ext_en`=1, a falling edge on `trig_pin` copies the counter into `rld_val` and sets `ext_flag`.
- R7: Up-count reload mode: with `ext_en`=1, a falling edge on `trig_pin` loads the counter from `rld_val` and sets `ext_flag`. With `ext_en`=0, the edge changes neither. The trigger acts even while `run_en` is 0.
- R8: Baud mode (`baud_rx_sel` or `baud_tx_sel` is 1) behaves as follows:
  - `cap_sel` is ignored.
  - The timer source is `st_tick`.
  - A step from 0xFFFF loads `rld_val` and gives a one-cycle `baud_pulse` in the next cycle.
  - `ovf_flag` is never set.
  - A trigger falling edge with `ext_en`=1 sets `ext_flag` without changing the counter.
- R9: Up/down mode (`cap_sel`=0, `updown_en`=1, not baud mode): the synchronized `trig_pin` level selects the direction, with 1 counting up and 0 counting down.
  - Counting up from 0xFFFF loads `rld_val`.
  - A down step taken while the counter equals `rld_val` loads 0xFFFF.
  - Both of these set `ovf_flag`.
- R10: In up/down mode `ext_flag` toggles on every overflow and every underflow, and trigger edges never set it, whatever `ext_en` is.
- R11: `wr_cnt` and `wr_rld` load `wr_data` into the counter or the reload register in the next cycle, overriding hardware updates. `clr_ovf` and `clr_ext` clear their flags, except that a hardware set in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mc_tick | input | 1 | Machine-cycle enable (oscillator/12) |
| st_tick | input | 1 | State-time enable (oscillator/2) |
| cnt_pin | input | 1 | External count input, asynchronous |
| trig_pin | input | 1 | External trigger/direction input, asynchronous |
| run_en | input | 1 | Run control |
| cnt_sel | input | 1 | 1: count pin edges, 0: count ticks |
| cap_sel | input | 1 | 1: capture mode, 0: reload modes |
| ext_en | input | 1 | Enables trigger-edge actions |
| updown_en | input | 1 | Enables up/down reload mode |
| baud_rx_sel | input | 1 | Receive baud clock select |
| baud_tx_sel | input | 1 | Transmit baud clock select |
| wr_cnt | input | 1 | Write `wr_data` into the counter |
| wr_rld | input | 1 | Write `wr_data` into the reload register |
| wr_data | input | 16 | Software write data |
| clr_ovf | input | 1 | Clear the overflow flag |
| clr_ext | input | 1 | Clear the external flag |
| cnt_val | output | 16 | Counter value |
| rld_val | output | 16 | Reload/capture register value |
| ovf_flag | output | 1 | Overflow flag, sticky |
| ext_flag | output | 1 | External/direction-wrap flag |
| baud_pulse | output | 1 | One-cycle pulse per baud-mode rollover |

## Verification
The bound checker watches several properties on every cycle:
- the counter holds while stopped;
- with the timer source, the counter is stable on cycles without a machine tick;
- the overflow flag stays set until it is cleared;
- baud mode never raises the overflow flag, and no baud pulse appears outside baud mode;
- software writes land in the next cycle.

Only the directed scenarios show the value-level behaviour. This covers wrap targets in each mode, capture contents, and edge counting on the count pin. It also covers the direction choice and the flag toggle in up/down mode, trigger edges that are ignored when disabled, and a hardware set winning over a clear in the same cycle.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

    typedef enum logic [1:0] {
        MODE_CAPTURE = 2'd0,
        MODE_RLD_UP  = 2'd1,
        MODE_RLD_UD  = 2'd2,
        MODE_BAUD    = 2'd3
    } tmr_mode_e;

    // Baud selection dominates; capture select is then ignored.
    function automatic tmr_mode_e pick_mode(input logic baud_any,
                                            input logic cap_sel,
                                            input logic updown_en);
        if (baud_any)       return MODE_BAUD;
        else if (cap_sel)   return MODE_CAPTURE;
        else if (updown_en) return MODE_RLD_UD;
        else                return MODE_RLD_UP;
    endfunction

endpackage

// File: rtl/tmr16_pin_edge.sv
module tmr16_pin_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic sample_en,
    output logic level,
    output logic fall
);
    localparam int LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], pin};
        if (sample_en) begin
            st_d.prev = st_q.sync[LAST];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level = st_q.sync[LAST];
    assign fall  = sample_en & st_q.prev & ~st_q.sync[LAST];

endmodule

// File: rtl/tmr16_step_gen.sv
module tmr16_step_gen
    import tmr16_pkg::*;
(
    input  logic      run_en,
    input  logic      cnt_sel,
    input  logic      cap_sel,
    input  logic      updown_en,
    input  logic      baud_rx_sel,
    input  logic      baud_tx_sel,
    input  logic      mc_tick,
    input  logic      st_tick,
    input  logic      cnt_fall,
    output tmr_mode_e mode,
    output logic      step
);
    logic baud_any;
    logic tick_src;

    always_comb begin
        baud_any = baud_rx_sel | baud_tx_sel;
        mode     = pick_mode(baud_any, cap_sel, updown_en);
        if (cnt_sel) begin
            tick_src = cnt_fall;
        end else if (mode == MODE_BAUD) begin
            tick_src = st_tick;
        end else begin
            tick_src = mc_tick;
        end
        step = run_en & tick_src;
    end

endmodule

// File: rtl/tmr16_core.sv
module tmr16_core
    import tmr16_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  tmr_mode_e     mode,
    input  logic          step,
    input  logic          dir_up,
    input  logic          trig_fall,
    input  logic          ext_en,
    input  logic          wr_cnt,
    input  logic          wr_rld,
    input  logic [CW-1:0] wr_data,
    input  logic          clr_ovf,
    input  logic          clr_ext,
    output logic [CW-1:0] cnt_val,
    output logic [CW-1:0] rld_val,
    output logic          ovf_flag,
    output logic          ext_flag,
    output logic          baud_pulse
);
    localparam logic [CW-1:0] ALL_ONES = {CW{1'b1}};
    localparam logic [CW-1:0] ONE      = {{(CW-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] rld;
        logic          ovf;
        logic          ext;
        logic          bpul;
    } core_st_t;

    core_st_t st_d, st_q;
    logic     at_top;
    logic     at_floor;
    logic     trig_act;

    always_comb begin
        at_top   = (st_q.cnt == ALL_ONES);
        at_floor = (st_q.cnt == st_q.rld);
        trig_act = ext_en & trig_fall;

        st_d      = st_q;
        st_d.bpul = 1'b0;
        st_d.ovf  = st_q.ovf & ~clr_ovf;
        st_d.ext  = st_q.ext & ~clr_ext;

        unique case (mode)
            MODE_BAUD: begin
                if (step) begin
                    if (at_top) begin
                        st_d.cnt  = st_q.rld;
                        st_d.bpul = 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt + ONE;
                    end
                end
                if (trig_act) begin
                    st_d.ext = 1'b1;
                end
            end
            MODE_CAPTURE: begin
                if (step) begin
                    st_d.cnt = st_q.cnt + ONE;
                    if (at_top) begin
                        st_d.ovf = 1'b1;
                    end
                end
                if (trig_act) begin
                    st_d.rld = st_q.cnt;
                    st_d.ext = 1'b1;
                end
            end
            MODE_RLD_UP: begin
                if (step) begin
                    if (at_top) begin
                        st_d.cnt = st_q.rld;
                        st_d.ovf = 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt + ONE;
                    end
                end
                if (trig_act) begin
                    st_d.cnt = st_q.rld;
                    st_d.ext = 1'b1;
                end
            end
            MODE_RLD_UD: begin
                if (step) begin
                    if (dir_up) begin
                        if (at_top) begin
                            st_d.cnt = st_q.rld;
                            st_d.ovf = 1'b1;
                            st_d.ext = ~st_q.ext;
                        end else begin
                            st_d.cnt = st_q.cnt + ONE;
                        end
                    end else begin
                        if (at_floor) begin
                            st_d.cnt = ALL_ONES;
                            st_d.ovf = 1'b1;
                            st_d.ext = ~st_q.ext;
                        end else begin
                            st_d.cnt = st_q.cnt - ONE;
                        end
                    end
                end
            end
            default: begin
                st_d = st_q;
            end
        endcase

        if (wr_cnt) begin
            st_d.cnt = wr_data;
        end
        if (wr_rld) begin
            st_d.rld = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_val    = st_q.cnt;
    assign rld_val    = st_q.rld;
    assign ovf_flag   = st_q.ovf;
    assign ext_flag   = st_q.ext;
    assign baud_pulse = st_q.bpul;

endmodule

// File: rtl/tmr16_reload.sv
module tmr16_reload
    import tmr16_pkg::*;
#(
    parameter int CW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mc_tick,
    input  logic          st_tick,
    input  logic          cnt_pin,
    input  logic          trig_pin,
    input  logic          run_en,
    input  logic          cnt_sel,
    input  logic          cap_sel,
    input  logic          ext_en,
    input  logic          updown_en,
    input  logic          baud_rx_sel,
    input  logic          baud_tx_sel,
    input  logic          wr_cnt,
    input  logic          wr_rld,
    input  logic [CW-1:0] wr_data,
    input  logic          clr_ovf,
    input  logic          clr_ext,
    output logic [CW-1:0] cnt_val,
    output logic [CW-1:0] rld_val,
    output logic          ovf_flag,
    output logic          ext_flag,
    output logic          baud_pulse
);
    logic      cnt_level, cnt_fall;
    logic      trig_level, trig_fall;
    tmr_mode_e mode;
    logic      step;

    tmr16_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_cnt_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin       (cnt_pin),
        .sample_en (mc_tick),
        .level     (cnt_level),
        .fall      (cnt_fall)
    );

    tmr16_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_trig_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin       (trig_pin),
        .sample_en (mc_tick),
        .level     (trig_level),
        .fall      (trig_fall)
    );

    tmr16_step_gen u_step (
        .run_en      (run_en),
        .cnt_sel     (cnt_sel),
        .cap_sel     (cap_sel),
        .updown_en   (updown_en),
        .baud_rx_sel (baud_rx_sel),
        .baud_tx_sel (baud_tx_sel),
        .mc_tick     (mc_tick),
        .st_tick     (st_tick),
        .cnt_fall    (cnt_fall),
        .mode        (mode),
        .step        (step)
    );

    tmr16_core #(.CW(CW)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .step       (step),
        .dir_up     (trig_level),
        .trig_fall  (trig_fall),
        .ext_en     (ext_en),
        .wr_cnt     (wr_cnt),
        .wr_rld     (wr_rld),
        .wr_data    (wr_data),
        .clr_ovf    (clr_ovf),
        .clr_ext    (clr_ext),
        .cnt_val    (cnt_val),
        .rld_val    (rld_val),
        .ovf_flag   (ovf_flag),
        .ext_flag   (ext_flag),
        .baud_pulse (baud_pulse)
    );

    logic unused_lvl;
    assign unused_lvl = cnt_level;

endmodule

// File: rtl/tmr16_chk.sv
module tmr16_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mc_tick,
    input logic          run_en,
    input logic          cnt_sel,
    input logic          ext_en,
    input logic          baud_rx_sel,
    input logic          baud_tx_sel,
    input logic          wr_cnt,
    input logic          wr_rld,
    input logic [CW-1:0] wr_data,
    input logic          clr_ovf,
    input logic [CW-1:0] cnt_val,
    input logic [CW-1:0] rld_val,
    input logic          ovf_flag,
    input logic          baud_pulse
);
    logic baud_any;
    assign baud_any = baud_rx_sel | baud_tx_sel;

    // R2
    stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !wr_cnt && !ext_en) |=> $stable(cnt_val));

    // R3
    timer_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !cnt_sel && !baud_any && !mc_tick && !wr_cnt && !ext_en)
        |=> $stable(cnt_val));

    // R5
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !clr_ovf) |=> ovf_flag);

    // R8
    baud_no_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (baud_any && !ovf_flag) |=> !ovf_flag);

    // R8
    baud_pulse_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !baud_any |=> !baud_pulse);

    // R11
    cnt_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> (cnt_val == $past(wr_data)));

    // R11
    rld_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_rld |=> (rld_val == $past(wr_data)));

endmodule

bind tmr16_reload tmr16_chk #(.CW(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mc_tick     (mc_tick),
    .run_en      (run_en),
    .cnt_sel     (cnt_sel),
    .ext_en      (ext_en),
    .baud_rx_sel (baud_rx_sel),
    .baud_tx_sel (baud_tx_sel),
    .wr_cnt      (wr_cnt),
    .wr_rld      (wr_rld),
    .wr_data     (wr_data),
    .clr_ovf     (clr_ovf),
    .cnt_val     (cnt_val),
    .rld_val     (rld_val),
    .ovf_flag    (ovf_flag),
    .baud_pulse  (baud_pulse)
);

// File: tb/sim_tmr16_reload.sv
`timescale 1ns/1ps
module sim_tmr16_reload;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mc_tick = 0, st_tick = 0, cnt_pin = 1, trig_pin = 1;
    logic run_en = 0, cnt_sel = 0, cap_sel = 0, ext_en = 0, updown_en = 0;
    logic baud_rx_sel = 0, baud_tx_sel = 0;
    logic wr_cnt = 0, wr_rld = 0, clr_ovf = 0, clr_ext = 0;
    logic [15:0] wr_data = '0;
    logic [15:0] cnt_val, rld_val;
    logic ovf_flag, ext_flag, baud_pulse;
    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    tmr16_reload u0 (
        .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .st_tick(st_tick),
        .cnt_pin(cnt_pin), .trig_pin(trig_pin), .run_en(run_en),
        .cnt_sel(cnt_sel), .cap_sel(cap_sel), .ext_en(ext_en),
        .updown_en(updown_en), .baud_rx_sel(baud_rx_sel),
        .baud_tx_sel(baud_tx_sel), .wr_cnt(wr_cnt), .wr_rld(wr_rld),
        .wr_data(wr_data), .clr_ovf(clr_ovf), .clr_ext(clr_ext),
        .cnt_val(cnt_val), .rld_val(rld_val), .ovf_flag(ovf_flag),
        .ext_flag(ext_flag), .baud_pulse(baud_pulse)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick_mc(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) mc_tick = 1'b1;
            @(negedge clk) mc_tick = 1'b0;
        end
    endtask

    task automatic tick_st(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) st_tick = 1'b1;
            @(negedge clk) st_tick = 1'b0;
        end
    endtask

    task automatic put_cnt(input logic [15:0] v);
        @(negedge clk) begin wr_cnt = 1'b1; wr_data = v; end
        @(negedge clk) wr_cnt = 1'b0;
    endtask

    task automatic put_rld(input logic [15:0] v);
        @(negedge clk) begin wr_rld = 1'b1; wr_data = v; end
        @(negedge clk) wr_rld = 1'b0;
    endtask

    task automatic clear_flags();
        @(negedge clk) begin clr_ovf = 1'b1; clr_ext = 1'b1; end
        @(negedge clk) begin clr_ovf = 1'b0; clr_ext = 1'b0; end
    endtask

    task automatic cnt_edge();
        @(negedge clk) cnt_pin = 1'b0;
        idle(3); tick_mc(1);
        @(negedge clk) cnt_pin = 1'b1;
        idle(3); tick_mc(1);
    endtask

    task automatic trig_edge();
        @(negedge clk) trig_pin = 1'b0;
        idle(3); tick_mc(1);
        @(negedge clk) trig_pin = 1'b1;
        idle(3); tick_mc(1);
    endtask

    task automatic t_reset();
        check("R1 cnt", cnt_val, 16'h0000);
        check("R1 rld", rld_val, 16'h0000);
        check("R1 flags", {ovf_flag, ext_flag, baud_pulse}, 3'b000);
    endtask

    task automatic t_write_hold();
        put_cnt(16'h1234);
        check("R11 cnt write", cnt_val, 16'h1234);
        tick_mc(5);
        tick_st(2);
        check("R2 stopped hold", cnt_val, 16'h1234);
    endtask

    task automatic t_timer();
        run_en = 1'b1;
        tick_mc(7);
        check("R3 tick count", cnt_val, 16'h123B);
        tick_st(3);
        check("R3 st_tick ignored", cnt_val, 16'h123B);
        run_en = 1'b0;
    endtask

    task automatic t_counter();
        cnt_sel = 1'b1;
        run_en  = 1'b1;
        for (int i = 0; i < 4; i++) cnt_edge();
        check("R4 pin edges", cnt_val, 16'h123F);
        tick_mc(3);
        check("R4 steady pin", cnt_val, 16'h123F);
        run_en  = 1'b0;
        cnt_sel = 1'b0;
    endtask

    task automatic t_reload_up();
        put_rld(16'hFFF0);
        put_cnt(16'hFFFE);
        run_en = 1'b1;
        tick_mc(2);
        check("R5 reload value", cnt_val, 16'hFFF0);
        check("R5 ovf set", ovf_flag, 1'b1);
        tick_mc(1);
        check("R5 ovf sticky", {ovf_flag, cnt_val}, {1'b1, 16'hFFF1});
        run_en = 1'b0;
        clear_flags();
        check("R11 ovf clear", ovf_flag, 1'b0);
    endtask

    task automatic t_trig_reload();
        put_rld(16'h5555);
        put_cnt(16'h0100);
        trig_edge();
        check("R7 trig ignored", {ext_flag, cnt_val}, {1'b0, 16'h0100});
        ext_en = 1'b1;
        trig_edge();
        check("R7 trig reload", {ext_flag, cnt_val}, {1'b1, 16'h5555});
        ext_en = 1'b0;
        clear_flags();
    endtask

    task automatic t_capture();
        cap_sel = 1'b1;
        put_cnt(16'hFFFF);
        run_en = 1'b1;
        tick_mc(1);
        check("R6 wrap zero", {ovf_flag, cnt_val}, {1'b1, 16'h0000});
        check("R6 rld kept", rld_val, 16'h5555);
        run_en = 1'b0;
        put_cnt(16'hABCD);
        ext_en = 1'b1;
        trig_edge();
        check("R6 capture", {ext_flag, rld_val}, {1'b1, 16'hABCD});
        ext_en  = 1'b0;
        cap_sel = 1'b0;
        clear_flags();
    endtask

    task automatic t_baud();
        put_rld(16'hFF00);
        put_cnt(16'hFFFD);
        baud_rx_sel = 1'b1;
        cap_sel     = 1'b1;
        run_en      = 1'b1;
        tick_st(2);
        check("R8 no pulse yet", {baud_pulse, cnt_val}, {1'b0, 16'hFFFF});
        tick_st(1);
        check("R8 rollover", {baud_pulse, cnt_val}, {1'b1, 16'hFF00});
        idle(1);
        check("R8 pulse width", baud_pulse, 1'b0);
        check("R8 no ovf", ovf_flag, 1'b0);
        run_en = 1'b0;
        ext_en = 1'b1;
        trig_edge();
        check("R8 trig flag only", {ext_flag, cnt_val}, {1'b1, 16'hFF00});
        ext_en      = 1'b0;
        cap_sel     = 1'b0;
        baud_rx_sel = 1'b0;
        clear_flags();
    endtask

    task automatic t_updown();
        updown_en = 1'b1;
        put_rld(16'h0010);
        put_cnt(16'h0012);
        @(negedge clk) trig_pin = 1'b0;
        idle(3);
        clear_flags();
        run_en = 1'b1;
        tick_mc(2);
        check("R9 count down", cnt_val, 16'h0010);
        tick_mc(1);
        check("R9 underflow", {ovf_flag, cnt_val}, {1'b1, 16'hFFFF});
        check("R10 ext toggle on", ext_flag, 1'b1);
        @(negedge clk) trig_pin = 1'b1;
        idle(3);
        tick_mc(1);
        check("R9 up wrap", cnt_val, 16'h0010);
        check("R10 ext toggle off", ext_flag, 1'b0);
        run_en = 1'b0;
        ext_en = 1'b1;
        trig_edge();
        check("R10 trig no ext", {ext_flag, cnt_val}, {1'b0, 16'h0010});
        ext_en    = 1'b0;
        updown_en = 1'b0;
        clear_flags();
    endtask

    task automatic t_set_wins();
        put_rld(16'h0000);
        put_cnt(16'hFFFF);
        run_en = 1'b1;
        @(negedge clk) begin mc_tick = 1'b1; clr_ovf = 1'b1; end
        @(negedge clk) begin mc_tick = 1'b0; clr_ovf = 1'b0; end
        check("R11 set beats clear", {ovf_flag, cnt_val}, {1'b1, 16'h0000});
        run_en = 1'b0;
    endtask

    initial begin
        idle(3);
        @(negedge clk) rst_n = 1'b1;
        idle(2);
        t_reset();
        t_write_hold();
        t_timer();
        t_counter();
        t_reload_up();
        t_trig_reload();
        t_capture();
        t_baud();
        t_updown();
        t_set_wins();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule